// File: doc/BRIEF.md
# Weighted Probabilistic Switch Arbiter

This block picks one winner per cycle from up to `N` requesters. Each requester presents a request bit and a small weight, and its chance of winning a given cycle equals its share of the total weight of all requesters active in that cycle. A requester with a larger weight (for example one whose traffic has come from further away) therefore wins more often. A requester with a small weight still keeps a nonzero chance, so it is never locked out.

A free-running linear feedback shift register supplies a new pseudo-random number every cycle. The number is scaled onto the range zero to the total weight. The active weights are accumulated in index order, and the winner is the first requester whose running sum passes the scaled number. The selection is purely combinational from the current inputs and the register state, so a grant appears in the same cycle as the request.

Top module: `wprob_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle, and a grant bit is only ever high for a requester whose `req` bit is high.
- R2: `grant_vld` is high exactly when at least one `req` bit is high. With no request, `grant` is all zero. This also applies right after reset.
- R3: The random source is a 16-bit register. Reset sets it to 0xACE1. On every clock edge out of reset it shifts left by one, and bit 0 takes the XOR of bits 15, 13, 12 and 10. It advances whether or not anything is requested or granted.
- R4: Let T be the total effective weight and R the register value. The scaled value is S = (R × T) >> 16. The grant goes to the lowest index whose running sum of effective weights (indices 0 up to and including that index) is strictly greater than S.
- R5: The weight of requester i is `weight[4i+3:4i]`. A requester whose `req` bit is low contributes zero weight.
- R6: An active requester with weight 0 counts as weight 1.
- R7: When exactly one request is active, it is granted in every cycle, whatever its weight.
- R8: Over many cycles, each requester's share of grants follows its share of the total weight. For weights 1 and 15, the heavier requester wins about 15 of every 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request bit per requester |
| weight | input | N*WW | Packed weights, WW bits per requester |
| grant | output | N | One-hot grant, or zero |
| grant_vld | output | 1 | High when a grant is issued |

## Verification
The hardest behaviour to reach from the ports is a particular boundary of the weighted selection: a cycle in which the scaled random value lands in the range of a specific requester. That value depends on the hidden register state. The bench therefore runs its own model of the shift register from the reset seed and computes the expected winner cycle by cycle. This lets it check exact grants for mixed weights, for zero weights and after idle stretches. A long run with weights 1 and 15 then checks the grant proportions statistically.

// File: rtl/wprob_arbiter.sv
module wprob_arbiter #(
  parameter int N = 4,
  parameter int WW = 4,
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N*WW-1:0] weight,
  output logic [N-1:0]    grant,
  output logic            grant_vld
);
  localparam int SW = WW + $clog2(N) + 1;

  logic [LW-1:0]    lfsr;
  logic [SW-1:0]    total;
  logic [LW+SW-1:0] prod;
  logic [SW-1:0]    scaled;
  logic [N-1:0]     above;

  function automatic logic [SW-1:0] eff_w(input logic r, input logic [WW-1:0] w);
    if (!r) return '0;
    if (w == '0) return SW'(1);
    return SW'(w);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[LW-2:0], ^(lfsr & TAPS)};

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + eff_w(req[i], weight[i*WW +: WW]);
  end

  assign prod   = {{SW{1'b0}}, lfsr} * {{LW{1'b0}}, total};
  assign scaled = prod[LW+SW-1:LW];

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + eff_w(req[i], weight[i*WW +: WW]);
      above[i] = acc > scaled;
    end
  end

  assign grant     = above & ~(above << 1);
  assign grant_vld = |req;

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  assert_valid_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0));
  assert_lfsr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr != '0) |=> (lfsr != '0) && (lfsr != $past(lfsr)));
  assert_lone_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) == 1) |-> (grant == req));
endmodule

// File: tb/wprob_arbiter_tb.sv
module wprob_arbiter_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  req = '0;
  logic [15:0] weight = '0;
  logic [3:0]  grant;
  logic        grant_vld;
  logic [15:0] m;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wprob_arbiter dut_i (.clk(clk), .rst_n(rst_n), .req(req), .weight(weight),
                       .grant(grant), .grant_vld(grant_vld));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m <= 16'hACE1;
    else        m <= {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};

  function automatic logic [3:0] expect_g(input logic [15:0] r, input logic [3:0] q,
                                          input logic [15:0] w);
    int t, s, acc, e [4];
    t = 0;
    for (int i = 0; i < 4; i++) begin
      e[i] = q[i] ? ((w[4*i +: 4] == 0) ? 1 : int'(w[4*i +: 4])) : 0;
      t += e[i];
    end
    s = (int'(r) * t) >>> 16;
    acc = 0;
    for (int i = 0; i < 4; i++) begin
      acc += e[i];
      if (acc > s) return 4'(1 << i);
    end
    return 4'b0;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step_check(input string tag, input logic [3:0] q, input logic [15:0] w);
    @(negedge clk);
    req = q; weight = w;
    #1;
    check(tag, {grant_vld, grant}, {|q, expect_g(m, q, w)});
  endtask

  task automatic t_reset;
    #1;
    check("R2 reset", {grant_vld, grant}, 5'b0);
    step_check("R2 idle", 4'b0000, 16'hFFFF);
  endtask

  task automatic t_lone;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); req = 4'(1 << (k % 4)); weight = 16'h0000; #1;
      check("R7 lone", {grant_vld, grant}, {1'b1, 4'(1 << (k % 4))});
    end
  endtask

  task automatic t_mixed;
    for (int k = 0; k < 10; k++) step_check("R4 R5 mixed", 4'b1111, 16'hF731);
    for (int k = 0; k < 10; k++) step_check("R5 partial", 4'b1010, 16'h2F9C);
  endtask

  task automatic t_equal;
    for (int k = 0; k < 10; k++) step_check("R4 equal", 4'b1111, 16'h5555);
  endtask

  task automatic t_zero;
    for (int k = 0; k < 10; k++) step_check("R6 zero", 4'b0101, 16'h0000);
    for (int k = 0; k < 6; k++)  step_check("R6 zero mix", 4'b0011, 16'h0030);
  endtask

  task automatic t_idle;
    @(negedge clk); req = '0;
    repeat (37) @(negedge clk);
    for (int k = 0; k < 6; k++) step_check("R3 after idle", 4'b1111, 16'h1248);
  endtask

  task automatic t_stats;
    int hi = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); req = 4'b0011; weight = 16'h00F1; #1;
      if (grant == 4'b0010) hi++;
    end
    tests++;
    if (hi < 1760 || hi > 1980) begin
      fails++;
      $display("FAIL R8 share actual=%0d expected=about 1875", hi);
    end
  endtask

  task automatic t_r1_subset;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); req = 4'b0110; weight = 16'hFFFF; #1;
      check("R1 subset", {1'b0, grant & ~req}, 5'b0);
    end
  endtask

  initial begin
    t_reset;
    @(negedge clk); rst_n = 1;
    t_reset;
    t_lone;
    t_mixed;
    t_equal;
    t_zero;
    t_idle;
    t_r1_subset;
    t_stats;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule